// File: doc/BRIEF.md
# Watchdog and Power-Fail Reset Controller

This block produces the processor reset from two causes. The first is a power-good flag from an external comparator, which the block qualifies with a hold time. The second is a software watchdog that supervises a strobe line driven by the processor. Time is counted in units of a one-cycle-wide tick-enable input, nominally one per millisecond. Every duration is a parameter in ticks, so a simulation can use short values.

Software services the watchdog by pulling the strobe from high to low. The strobe is synchronized before its falling edge is detected. If no such edge arrives within the selected period, the block raises reset for a fixed number of ticks. It then restarts the period. While the strobe stays idle, a new reset pulse follows at every further period. The reset is driven on two pins of opposite polarity.

Top module: `wdog_por_ctrl`

## Requirements
- R1: Whenever `pwr_good_i` is sampled low at a clock edge, `rst_o` is 1 from the following cycle on. It stays 1 for as long as `pwr_good_i` stays low.
- R2: Once `pwr_good_i` is high, power reset ends on the HOLD_TICKS-th tick that is seen while it stays high without a break (default 250). Any low cycle clears this count.
- R3: Only a high-to-low transition of `strobe_i` restarts the watchdog period. A rising edge or a steady level leaves the count unchanged.
- R4: `tmo_sel_i` picks the period: 2'b00 selects TMO0_TICKS (150), 2'b01 selects TMO1_TICKS (600), and 2'b10 or 2'b11 selects TMO2_TICKS (1200). The select is captured whenever the watchdog count restarts: on a valid service, at the end of a reset pulse, and while power reset is active.
- R5: If the count reaches the selected period without a service, reset rises on that tick. It falls again on the PULSE_TICKS-th tick after that (default 250).
- R6: While the strobe stays unserviced, a further reset pulse starts every selected period after the previous pulse ends.
- R7: `rst_no` is always the inverse of `rst_o`.
- R8: During a watchdog reset pulse the period count is held at zero, so strobe edges have no effect on it. Counting restarts from zero when the pulse ends.
- R9: While `rst_ni` is low, `rst_o` is 1 and the power-good hold count is cleared. After `rst_ni` is released, the full hold time of R2 is needed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to clk_i |
| tick_i | input | 1 | One-cycle time-base enable, one per millisecond |
| pwr_good_i | input | 1 | Power-good flag, synchronous to clk_i |
| strobe_i | input | 1 | Watchdog service line; a falling edge services it |
| tmo_sel_i | input | 2 | Watchdog period select |
| rst_o | output | 1 | Processor reset, active high |
| rst_no | output | 1 | Processor reset, active low |

## Verification
The properties assume that `pwr_good_i` is already synchronous to the clock. They also assume that `tick_i` is a single-cycle pulse, so that each change of reset can be traced either to a tick or to a power-good drop in the cycle before. The stimulus changes `pwr_good_i`, `strobe_i` and `tmo_sel_i` only in cycles without a tick. After each change it waits several tick-free cycles so the strobe synchronizer settles before the next tick. As a result, a service and a tick never meet in the same cycle.

// File: rtl/wdpr_pkg.sv
package wdpr_pkg;

  typedef enum logic {
    WD_WATCH = 1'b0,
    WD_PULSE = 1'b1
  } wd_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wdpr_strobe_edge.sv
module wdpr_strobe_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= strobe_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/wdpr_pwr_hold.sv
module wdpr_pwr_hold #(
  parameter int unsigned HOLD_TICKS = 250,
  localparam int unsigned HW = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pwr_good_i,
  output logic ok_o
);

  logic [HW-1:0] cnt_q, cnt_d;
  logic          ok_q, ok_d;

  always_comb begin
    cnt_d = cnt_q;
    ok_d  = ok_q;
    if (!pwr_good_i) begin
      cnt_d = '0;
      ok_d  = 1'b0;
    end else if (tick_i && !ok_q) begin
      if (cnt_q == HW'(HOLD_TICKS - 1)) begin
        cnt_d = '0;
        ok_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
    end
  end

  assign ok_o = ok_q;

endmodule

// File: rtl/wdpr_wdog_core.sv
module wdpr_wdog_core
  import wdpr_pkg::*;
#(
  parameter int unsigned TMO0_TICKS  = 150,
  parameter int unsigned TMO1_TICKS  = 600,
  parameter int unsigned TMO2_TICKS  = 1200,
  parameter int unsigned PULSE_TICKS = 250,
  parameter int unsigned CW          = 11,
  localparam int unsigned PW = $clog2(PULSE_TICKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          arm_i,
  input  logic          fall_i,
  input  logic [1:0]    sel_i,
  output logic          pulse_o,
  output logic [CW-1:0] cnt_o
);

  wd_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q, lim_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [CW-1:0] sel_lim;

  always_comb begin
    if (sel_i[1])      sel_lim = CW'(TMO2_TICKS);
    else if (sel_i[0]) sel_lim = CW'(TMO1_TICKS);
    else               sel_lim = CW'(TMO0_TICKS);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    pcnt_d  = pcnt_q;
    if (!arm_i) begin
      state_d = WD_WATCH;
      cnt_d   = '0;
      pcnt_d  = '0;
      lim_d   = sel_lim;
    end else begin
      unique case (state_q)
        WD_WATCH: begin
          if (fall_i) begin
            cnt_d = '0;
            lim_d = sel_lim;
          end else if (tick_i) begin
            if (cnt_q == lim_q - 1'b1) begin
              state_d = WD_PULSE;
              cnt_d   = '0;
              pcnt_d  = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        WD_PULSE: begin
          cnt_d = '0;
          if (tick_i) begin
            if (pcnt_q == PW'(PULSE_TICKS - 1)) begin
              state_d = WD_WATCH;
              pcnt_d  = '0;
              lim_d   = sel_lim;
            end else begin
              pcnt_d = pcnt_q + 1'b1;
            end
          end
        end
        default: state_d = WD_WATCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_WATCH;
      cnt_q   <= '0;
      lim_q   <= CW'(TMO0_TICKS);
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign pulse_o = (state_q == WD_PULSE);
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/wdog_por_ctrl.sv
module wdog_por_ctrl
  import wdpr_pkg::*;
#(
  parameter int unsigned HOLD_TICKS  = 250,
  parameter int unsigned PULSE_TICKS = 250,
  parameter int unsigned TMO0_TICKS  = 150,
  parameter int unsigned TMO1_TICKS  = 600,
  parameter int unsigned TMO2_TICKS  = 1200,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = $clog2(max3(TMO0_TICKS, TMO1_TICKS, TMO2_TICKS) + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       pwr_good_i,
  input  logic       strobe_i,
  input  logic [1:0] tmo_sel_i,
  output logic       rst_o,
  output logic       rst_no
);

  logic          pg_ok;
  logic          st_fall;
  logic          wd_pulse;
  logic [CW-1:0] wd_cnt;

  wdpr_strobe_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .fall_o  (st_fall)
  );

  wdpr_pwr_hold #(
    .HOLD_TICKS(HOLD_TICKS)
  ) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .pwr_good_i(pwr_good_i),
    .ok_o      (pg_ok)
  );

  wdpr_wdog_core #(
    .TMO0_TICKS (TMO0_TICKS),
    .TMO1_TICKS (TMO1_TICKS),
    .TMO2_TICKS (TMO2_TICKS),
    .PULSE_TICKS(PULSE_TICKS),
    .CW         (CW)
  ) u_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .arm_i  (pg_ok),
    .fall_i (st_fall),
    .sel_i  (tmo_sel_i),
    .pulse_o(wd_pulse),
    .cnt_o  (wd_cnt)
  );

  assign rst_o  = ~pg_ok | wd_pulse;
  assign rst_no = ~rst_o;

endmodule

// File: rtl/wdog_por_ctrl_chk.sv
module wdog_por_ctrl_chk #(
  parameter int unsigned CW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          pwr_good_i,
  input logic          rst_o,
  input logic          wd_pulse,
  input logic [CW-1:0] wd_cnt
);

  // R1
  pg_low_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> rst_o);

  // R2
  rst_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> ($past(tick_i) && $past(pwr_good_i)));

  // R5
  rst_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> ($past(tick_i) || !$past(pwr_good_i)));

  // R5
  pulse_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wd_pulse) |-> $past(tick_i));

  // R8
  pulse_cnt_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_pulse |-> (wd_cnt == '0));

endmodule

bind wdog_por_ctrl wdog_por_ctrl_chk #(.CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .pwr_good_i(pwr_good_i),
  .rst_o     (rst_o),
  .wd_pulse  (wd_pulse),
  .wd_cnt    (wd_cnt)
);

// File: tb/wdog_por_ctrl_tb.sv
module wdog_por_ctrl_tb;

  localparam int unsigned HOLD  = 5;
  localparam int unsigned PULSE = 4;
  localparam int unsigned T0    = 6;
  localparam int unsigned T1    = 10;
  localparam int unsigned T2    = 14;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic       pg = 1'b0;
  logic       st = 1'b1;
  logic [1:0] sel = 2'd0;
  logic       rst_o, rst_no;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_por_ctrl #(
    .HOLD_TICKS (HOLD),
    .PULSE_TICKS(PULSE),
    .TMO0_TICKS (T0),
    .TMO1_TICKS (T1),
    .TMO2_TICKS (T2)
  ) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .pwr_good_i(pg),
    .strobe_i  (st),
    .tmo_sel_i (sel),
    .rst_o     (rst_o),
    .rst_no    (rst_no)
  );

  // fields: pg, strobe, sel[1:0], ticks[7:0], expected rst_o, requirement[3:0]
  localparam int NV = 36;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 1'b1, 2'd0, 8'd4,  1'b1, 4'd2},  // R2 hold not yet met
    {1'b1, 1'b1, 2'd0, 8'd1,  1'b0, 4'd2},  // R2 released on HOLD-th tick
    {1'b1, 1'b1, 2'd0, 8'd5,  1'b0, 4'd5},  // R5 below period
    {1'b1, 1'b0, 2'd0, 8'd5,  1'b0, 4'd3},  // R3 fall restarts count
    {1'b1, 1'b1, 2'd0, 8'd1,  1'b1, 4'd3},  // R3 rise ignored, expiry
    {1'b1, 1'b1, 2'd0, 8'd3,  1'b1, 4'd5},  // R5 pulse still high
    {1'b1, 1'b1, 2'd0, 8'd1,  1'b0, 4'd5},  // R5 pulse ends
    {1'b1, 1'b1, 2'd0, 8'd5,  1'b0, 4'd6},  // R6
    {1'b1, 1'b1, 2'd0, 8'd1,  1'b1, 4'd6},  // R6 repeated pulse
    {1'b1, 1'b1, 2'd0, 8'd4,  1'b0, 4'd6},  // R6
    {1'b1, 1'b0, 2'd1, 8'd9,  1'b0, 4'd4},  // R4 sel 01 captured on fall
    {1'b1, 1'b0, 2'd1, 8'd1,  1'b1, 4'd4},  // R4 period 10
    {1'b1, 1'b0, 2'd1, 8'd4,  1'b0, 4'd5},
    {1'b1, 1'b0, 2'd1, 8'd9,  1'b0, 4'd4},  // R4 captured at pulse end
    {1'b1, 1'b0, 2'd1, 8'd1,  1'b1, 4'd4},
    {1'b1, 1'b0, 2'd1, 8'd4,  1'b0, 4'd5},
    {1'b1, 1'b1, 2'd2, 8'd0,  1'b0, 4'd3},
    {1'b1, 1'b0, 2'd2, 8'd13, 1'b0, 4'd4},  // R4 sel 10
    {1'b1, 1'b0, 2'd2, 8'd1,  1'b1, 4'd4},
    {1'b1, 1'b0, 2'd2, 8'd4,  1'b0, 4'd5},
    {1'b1, 1'b1, 2'd3, 8'd0,  1'b0, 4'd3},
    {1'b1, 1'b0, 2'd3, 8'd13, 1'b0, 4'd4},  // R4 sel 11
    {1'b1, 1'b0, 2'd3, 8'd1,  1'b1, 4'd4},
    {1'b1, 1'b0, 2'd3, 8'd4,  1'b0, 4'd5},
    {1'b0, 1'b0, 2'd3, 8'd0,  1'b1, 4'd1},  // R1 power lost
    {1'b1, 1'b0, 2'd3, 8'd3,  1'b1, 4'd2},
    {1'b0, 1'b0, 2'd3, 8'd0,  1'b1, 4'd1},  // R1 dropout
    {1'b1, 1'b0, 2'd3, 8'd4,  1'b1, 4'd2},  // R2 count restarted
    {1'b1, 1'b0, 2'd3, 8'd1,  1'b0, 4'd2},
    {1'b1, 1'b1, 2'd3, 8'd13, 1'b0, 4'd3},  // R3 rise ignored
    {1'b1, 1'b1, 2'd3, 8'd1,  1'b1, 4'd5},
    {1'b1, 1'b0, 2'd3, 8'd2,  1'b1, 4'd8},  // R8 fall during pulse
    {1'b1, 1'b0, 2'd3, 8'd1,  1'b1, 4'd8},
    {1'b1, 1'b0, 2'd3, 8'd1,  1'b0, 4'd8},  // R8 width unchanged
    {1'b1, 1'b0, 2'd3, 8'd13, 1'b0, 4'd8},  // R8 restart from zero
    {1'b1, 1'b0, 2'd3, 8'd1,  1'b1, 4'd8}
  };

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic check(input int req, input logic exp, input string what);
    checks++;
    if (rst_o !== exp) begin
      errors++;
      $display("FAIL R%0d %s: rst_o=%b expected %b", req, what, rst_o, exp);
    end
    checks++;
    if (rst_no !== ~exp) begin
      errors++;
      $display("FAIL R7 %s: rst_no=%b expected %b", what, rst_no, ~exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, finished=%b expected 1", done);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    check(9, 1'b1, "reset state");  // R9
    @(negedge clk);
    rst_ni = 1'b1;
    idle(4);
    check(9, 1'b1, "after release, power low");  // R9 and R1

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pg  = VEC[i][16];
      st  = VEC[i][15];
      sel = VEC[i][14:13];
      idle(5);
      ticks(int'(VEC[i][12:5]));
      idle(1);
      check(int'(VEC[i][3:0]), VEC[i][4], $sformatf("step %0d", i));
    end

    // R9: asynchronous reset mid-run clears the hold count
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(9, 1'b1, "reset asserted mid-run");
    idle(2);
    rst_ni = 1'b1;
    idle(3);
    ticks(HOLD - 1);
    idle(1);
    check(9, 1'b1, "hold restarted after reset");
    ticks(1);
    idle(1);
    check(9, 1'b0, "released after full hold");

    // R1: power dropout during a watchdog pulse keeps reset asserted
    st = 1'b1;
    idle(5);
    ticks(T2);
    idle(1);
    check(5, 1'b1, "expiry at sel 11");
    pg = 1'b0;
    idle(2);
    ticks(PULSE);
    idle(1);
    check(1, 1'b1, "power low outlasts pulse");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule